// File: doc/BRIEF.md
# Out-of-Range Code Corrector for a Three-Stage Pipelined Successive-Approximation Converter

The block merges the partial codes of three cascaded successive-approximation stages into one output word and repairs the one-LSB slips that comparator offset causes. Each stage resolves its own bits. The residue it leaves is amplified and handed to the next stage. Two extra comparators watch every amplified residue. One fires when the next stage's input lies below zero, which means the earlier stage's code is one LSB too high. The other fires when that input lies above the reference, which means the earlier code is one LSB too low. The offset is assumed to stay under one stage LSB, so the error can only be −1, 0 or +1 LSB.

A sample enters as a skewed stream. The first stage's code arrives with `valid_in`. One cycle later come the second stage's code and the range flags for the first/second boundary. One cycle after that come the third stage's code and the flags for the second/third boundary. The block applies the signed adjustment to the earlier code at each boundary, saturating at zero and at all-ones. It realigns the three codes and registers the merged word, which adds one cycle of latency. For each boundary it also sends a one-cycle add or subtract request to the analog residue path.

Top module: `psac_code_fix`

## Requirements
- R1: `valid_out` is high in exactly the cycle that follows the third rising edge counted from the edge that captures `valid_in`. A new sample is accepted in every cycle, with no gap required.
- R2: With no flag raised at either boundary, `word_out` equals {first code, second code, third code}. The first code is in the most significant bits and the third code in the least significant bits.
- R3: If only `below_ab` is high in the cycle after `valid_in`, the first-stage field of the word is the first code minus one. A first code of zero stays zero.
- R4: If only `above_ab` is high in the cycle after `valid_in`, the first-stage field is the first code plus one. A first code of all-ones stays all-ones.
- R5: The flags `below_bc` and `above_bc`, sampled two cycles after `valid_in`, adjust the second-stage field in the same way: below alone subtracts one (floor at zero), and above alone adds one (ceiling at all-ones). The third-stage field is never altered.
- R6: If both flags of a boundary are high, `err_out` is high together with that sample's `valid_out`. The code at that boundary is passed unchanged, and that boundary raises no request.
- R7: A below flag at a valid boundary sets `add_req[k]` high for exactly one cycle, in the cycle after the flag is sampled. An above flag does the same for `sub_req[k]`. Here k=0 is the first/second boundary and k=1 is the second/third boundary.
- R8: Flags that arrive in a cycle that carries no valid sample for that boundary are ignored: they raise no request.
- R9: While `rst_n` is low, `valid_out`, `err_out`, `word_out`, `add_req` and `sub_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | First-stage code of a new sample is present |
| code_a | input | WA | First-stage code |
| code_b | input | WB | Second-stage code, one cycle after valid_in |
| below_ab | input | 1 | Second-stage input below zero |
| above_ab | input | 1 | Second-stage input above reference |
| code_c | input | WC | Third-stage code, two cycles after valid_in |
| below_bc | input | 1 | Third-stage input below zero |
| above_bc | input | 1 | Third-stage input above reference |
| valid_out | output | 1 | Corrected word present |
| word_out | output | WA+WB+WC | Corrected merged code |
| err_out | output | 1 | Contradictory flags seen for this sample |
| add_req | output | 2 | Add-one-LSB request per boundary |
| sub_req | output | 2 | Subtract-one-LSB request per boundary |

## Verification
Stimulus is driven on the falling edge and results are read on a later falling edge. For a sample whose first code is captured at edge n, the word, `valid_out` and `err_out` are read after edge n+2, which is three falling-edge steps later. The second-boundary requests are read at that same point. The first-boundary requests are read one step earlier, after edge n+1. The bench keeps the stimulus of every slot and looks back by exactly those distances to compute the expected values. It sweeps every code and flag combination of the default configuration and mixes in idle slots that carry junk flags.

// File: rtl/psac_fix_pkg.sv
package psac_fix_pkg;

    // Out-of-range indications for one amplified residue
    typedef struct packed {
        logic below;
        logic above;
    } range_flags_t;

    // Both indications at once is physically contradictory
    function automatic logic flags_clash(range_flags_t f);
        return f.below & f.above;
    endfunction

endpackage

// File: rtl/psac_lsb_adjust.sv
module psac_lsb_adjust
    import psac_fix_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] code_i,
    input  range_flags_t flags_i,
    output logic [W-1:0] code_o,
    output logic         add_o,
    output logic         sub_o,
    output logic         clash_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] FULL = '1;

    always_comb begin
        code_o  = code_i;
        add_o   = 1'b0;
        sub_o   = 1'b0;
        clash_o = 1'b0;
        if (vld_i) begin
            if (flags_clash(flags_i)) begin
                clash_o = 1'b1;
            end else if (flags_i.below) begin
                // earlier code one LSB high: lower it, residue needs an add
                add_o = 1'b1;
                if (code_i != ZERO) code_o = code_i - ONE;
            end else if (flags_i.above) begin
                // earlier code one LSB low: raise it, residue needs a subtract
                sub_o = 1'b1;
                if (code_i != FULL) code_o = code_i + ONE;
            end
        end
    end

    // R4 / R3: saturation, never a wrap between the two extremes
    p_no_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == FULL) |-> (code_o != ZERO));
    p_no_wrap_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == ZERO) |-> (code_o != FULL));

endmodule

// File: rtl/psac_req_reg.sv
module psac_req_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic sub_i,
    output logic add_o,
    output logic sub_o
);
    typedef struct packed {
        logic add;
        logic sub;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d.add = add_i;
        req_d.sub = sub_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign add_o = req_q.add;
    assign sub_o = req_q.sub;

    // R7: one boundary never asks for both directions
    p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_o && sub_o));

endmodule

// File: rtl/psac_code_fix.sv
module psac_code_fix
    import psac_fix_pkg::*;
#(
    parameter int WA = 3,
    parameter int WB = 3,
    parameter int WC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_in,
    input  logic [WA-1:0]         code_a,
    input  logic [WB-1:0]         code_b,
    input  logic                  below_ab,
    input  logic                  above_ab,
    input  logic [WC-1:0]         code_c,
    input  logic                  below_bc,
    input  logic                  above_bc,
    output logic                  valid_out,
    output logic [WA+WB+WC-1:0]   word_out,
    output logic                  err_out,
    output logic [1:0]            add_req,
    output logic [1:0]            sub_req
);
    localparam int WT = WA + WB + WC;
    localparam int NB = 2;

    typedef struct packed {
        logic          v;
        logic [WA-1:0] a;
    } lane1_t;

    typedef struct packed {
        logic          v;
        logic [WA-1:0] a;
        logic [WB-1:0] b;
        logic          clash;
    } lane2_t;

    typedef struct packed {
        logic          v;
        logic [WT-1:0] word;
        logic          err;
    } lane3_t;

    typedef struct packed {
        lane1_t l1;
        lane2_t l2;
        lane3_t l3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    range_flags_t  flags_ab, flags_bc;
    logic [WA-1:0] a_fixed;
    logic [WB-1:0] b_fixed;
    logic [NB-1:0] adj_add, adj_sub, adj_clash;

    assign flags_ab = '{below: below_ab, above: above_ab};
    assign flags_bc = '{below: below_bc, above: above_bc};

    // boundary first/second: flags arrive with the second code
    psac_lsb_adjust #(.W(WA)) u_adj_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (pipe_q.l1.v),
        .code_i  (pipe_q.l1.a),
        .flags_i (flags_ab),
        .code_o  (a_fixed),
        .add_o   (adj_add[0]),
        .sub_o   (adj_sub[0]),
        .clash_o (adj_clash[0])
    );

    // boundary second/third: flags arrive with the third code
    psac_lsb_adjust #(.W(WB)) u_adj_bc (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (pipe_q.l2.v),
        .code_i  (pipe_q.l2.b),
        .flags_i (flags_bc),
        .code_o  (b_fixed),
        .add_o   (adj_add[1]),
        .sub_o   (adj_sub[1]),
        .clash_o (adj_clash[1])
    );

    for (genvar k = 0; k < NB; k++) begin : g_req
        psac_req_reg u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .add_i (adj_add[k]),
            .sub_i (adj_sub[k]),
            .add_o (add_req[k]),
            .sub_o (sub_req[k])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        // lane 1: capture first-stage code
        pipe_d.l1.v     = valid_in;
        pipe_d.l1.a     = code_a;
        // lane 2: corrected first code, raw second code
        pipe_d.l2.v     = pipe_q.l1.v;
        pipe_d.l2.a     = a_fixed;
        pipe_d.l2.b     = code_b;
        pipe_d.l2.clash = adj_clash[0];
        // lane 3: merged word (extra register stage)
        pipe_d.l3.v     = pipe_q.l2.v;
        pipe_d.l3.word  = {pipe_q.l2.a, b_fixed, code_c};
        pipe_d.l3.err   = pipe_q.l2.clash | adj_clash[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign valid_out = pipe_q.l3.v;
    assign word_out  = pipe_q.l3.word;
    assign err_out   = pipe_q.l3.err;

    // R1: fixed latency in both directions
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |-> ##3 valid_out);
    p_no_ghost_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |-> ##3 !valid_out);

    // R6: contradictory flags give an error flag and no request
    p_clash_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.l1.v && below_ab && above_ab) |-> ##2 err_out);
    p_clash_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.l2.v && below_bc && above_bc) |=> (!add_req[1] && !sub_req[1]));

    // R8: requests only for slots that hold a sample
    p_req_slot_ab_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req[0] || sub_req[0]) |-> $past(pipe_q.l1.v));
    p_req_slot_bc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req[1] || sub_req[1]) |-> $past(pipe_q.l2.v));

endmodule

// File: tb/psac_code_fix_bench.sv
`timescale 1ns/1ps
module psac_code_fix_bench;
    localparam int WA = 3;
    localparam int WB = 3;
    localparam int WC = 2;
    localparam int WT = WA + WB + WC;
    localparam int NV = 1 << (WA + WB + WC + 4);
    localparam int MAXS = 4800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_in = 1'b0;
    logic [WA-1:0] code_a = '0;
    logic [WB-1:0] code_b = '0;
    logic [WC-1:0] code_c = '0;
    logic below_ab = 1'b0, above_ab = 1'b0, below_bc = 1'b0, above_bc = 1'b0;
    logic valid_out, err_out;
    logic [WT-1:0] word_out;
    logic [1:0] add_req, sub_req;

    always #2.5 clk = ~clk;

    psac_code_fix #(.WA(WA), .WB(WB), .WC(WC)) u_psac_code_fix (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .code_a(code_a), .code_b(code_b), .below_ab(below_ab), .above_ab(above_ab),
        .code_c(code_c), .below_bc(below_bc), .above_bc(above_bc),
        .valid_out(valid_out), .word_out(word_out), .err_out(err_out),
        .add_req(add_req), .sub_req(sub_req)
    );

    // slot stimulus; flags bit0 = below, bit1 = above
    bit       s_v  [MAXS];
    int       s_a  [MAXS];
    int       s_b  [MAXS];
    int       s_c  [MAXS];
    int       s_fab[MAXS];
    int       s_fbc[MAXS];
    int       nslots = 0;
    int       checks = 0;
    int       fails = 0;
    bit       done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int adj(input int code, input int f, input int w);
        int top;
        top = (1 << w) - 1;
        if (f == 1) return (code == 0) ? 0 : code - 1;
        if (f == 2) return (code == top) ? top : code + 1;
        return code;
    endfunction

    // word, valid, error, second-boundary requests for slot s
    task automatic check_main(input int s);
        string tag;
        int ew;
        chk("R1 valid_out", 32'(valid_out), 32'(s_v[s]));
        if (s_v[s]) begin
            if (s_fab[s] == 3 || s_fbc[s] == 3) tag = "R6 word";
            else if (s_fab[s] == 1) tag = "R3 word";
            else if (s_fab[s] == 2) tag = "R4 word";
            else if (s_fbc[s] != 0) tag = "R5 word";
            else tag = "R2 word";
            ew = (adj(s_a[s], s_fab[s], WA) << (WB + WC)) |
                 (adj(s_b[s], s_fbc[s], WB) << WC) | s_c[s];
            chk(tag, 32'(word_out), 32'(ew));
            chk("R6 err_out", 32'(err_out), 32'((s_fab[s] == 3) || (s_fbc[s] == 3)));
            chk("R7 add_req[1]", 32'(add_req[1]), 32'(s_fbc[s] == 1));
            chk("R7 sub_req[1]", 32'(sub_req[1]), 32'(s_fbc[s] == 2));
        end else begin
            chk("R8 idle add_req[1]", 32'(add_req[1]), 32'(0));
            chk("R8 idle sub_req[1]", 32'(sub_req[1]), 32'(0));
        end
    endtask

    task automatic check_ab(input int s);
        if (s_v[s]) begin
            chk("R7 add_req[0]", 32'(add_req[0]), 32'(s_fab[s] == 1));
            chk("R7 sub_req[0]", 32'(sub_req[0]), 32'(s_fab[s] == 2));
        end else begin
            chk("R8 idle add_req[0]", 32'(add_req[0]), 32'(0));
            chk("R8 idle sub_req[0]", 32'(sub_req[0]), 32'(0));
        end
    endtask

    task automatic drive(input int n);
        valid_in = s_v[n];
        code_a   = WA'(s_a[n]);
        if (n >= 1) begin
            code_b   = WB'(s_b[n-1]);
            below_ab = s_fab[n-1][0];
            above_ab = s_fab[n-1][1];
        end
        if (n >= 2) begin
            code_c   = WC'(s_c[n-2]);
            below_bc = s_fbc[n-2][0];
            above_bc = s_fbc[n-2][1];
        end
    endtask

    initial begin
        int i;
        i = 0;
        for (int k = 0; k < MAXS; k++) begin
            s_v[k] = 1'b0; s_a[k] = k % 7; s_b[k] = k % 5; s_c[k] = k % 3;
            s_fab[k] = k % 4; s_fbc[k] = (k + 1) % 4;   // junk for idle slots
        end
        while (i < NV) begin
            if (nslots % 9 != 8) begin
                s_v[nslots]   = 1'b1;
                s_c[nslots]   = i % (1 << WC);
                s_b[nslots]   = (i >> WC) % (1 << WB);
                s_a[nslots]   = (i >> (WC + WB)) % (1 << WA);
                s_fab[nslots] = (i >> WT) % 4;
                s_fbc[nslots] = (i >> (WT + 2)) % 4;
                i++;
            end
            nslots++;
        end
        for (int k = nslots; k < MAXS; k++) s_v[k] = 1'b0;

        // R9: reset state, with junk on the inputs
        below_ab = 1'b1; above_bc = 1'b1; valid_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 valid_out", 32'(valid_out), 0);
        chk("R9 err_out", 32'(err_out), 0);
        chk("R9 word_out", 32'(word_out), 0);
        chk("R9 add_req", 32'(add_req), 0);
        chk("R9 sub_req", 32'(sub_req), 0);
        valid_in = 1'b0; below_ab = 1'b0; above_bc = 1'b0;
        rst_n = 1'b1;

        for (int n = 0; n < nslots + 4; n++) begin
            if (n > 0) @(negedge clk);
            if (n >= 3) check_main(n - 3);
            if (n >= 2) check_ab(n - 2);
            drive(n);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule